// File: doc/BRIEF.md
# Pulse Width Capture Timer

This block measures the time between qualifying transitions on an asynchronous input pin. A free-running up-counter advances once per count tick. A separate enable strobe supplies the ticks, so any prescaler stays outside the block. When a transition of the selected polarity is seen, the counter value is latched into a capture register and the counter restarts from zero. Each captured value is therefore one complete interval, and a single-cycle capture pulse tells the system that a new value is waiting.

If no transition arrives before the counter passes its all-ones value, the counter rolls over to zero and keeps counting. The rollover raises a single-cycle overflow pulse and sets a sticky overflow flag. Software reads the flag to extend a measurement across one rollover and then clears it with a strobe. For the first interval after start, the width in ticks is the captured value plus one. When the flag is set, the width is the captured value plus 0x10001.

Top module: `pwcap_timer`

## Requirements
- R1: After reset, `cap_val_o` is 0, `cap_pulse_o` and `ovf_pulse_o` are 0, and `ovf_flag_o` is 0.
- R2: While `run_i` is 0, the counter is held at 0 and input transitions cause no capture: `cap_pulse_o` stays 0 and `cap_val_o` keeps its last value. When `run_i` returns to 1, counting restarts from 0.
- R3: A pin change is seen after a two-flop synchronizer and one compare stage. When the change qualifies, the clock edge that acts on it copies the counter into `cap_val_o` and clears the counter, and `cap_pulse_o` is 1 for the following cycle. With ticks on every cycle, consecutive captures that are N clocks apart give N-1. The first capture after `run_i` rises gives the number of clocks since `run_i` was set, minus one.
- R4: `edge_sel_i` picks the qualifying transition: 2'b00 none, 2'b01 low-to-high, 2'b10 high-to-low, 2'b11 either.
- R5: The counter advances only on clocks where `tick_i` is 1. Transitions are detected and captured on every clock, whatever the value of `tick_i`.
- R6: A tick while the counter holds 0xFFFF returns the counter to 0, and `ovf_pulse_o` is 1 for exactly one cycle. Counting then continues from 0.
- R7: Every overflow sets `ovf_flag_o`. The flag stays set until a `flag_clr_i` strobe, which clears it on the next clock.
- R8: When a qualifying transition and a rollover fall on the same clock, the capture wins: 0xFFFF is captured, the counter goes to 0, and both `cap_pulse_o` and `ovf_pulse_o` are raised along with the flag.
- R9: When `flag_clr_i` coincides with a new overflow, `ovf_flag_o` ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Run enable; 0 holds the counter at zero |
| edge_sel_i | input | 2 | Qualifying transition: 00 none, 01 rise, 10 fall, 11 both |
| pin_i | input | 1 | Asynchronous measured input |
| tick_i | input | 1 | Count enable strobe |
| flag_clr_i | input | 1 | Clears the sticky overflow flag |
| cap_val_o | output | CNT_W (16) | Last captured interval |
| cap_pulse_o | output | 1 | One-cycle capture event |
| ovf_pulse_o | output | 1 | One-cycle rollover event |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
The bench times one transition so that its capture lands on the very clock where the counter rolls over. A design that let the rollover win would capture zero or lose the capture pulse, and a design that dropped the flag in that case would under-report the interval by 65536. The same clock also carries a flag-clear strobe, which catches a design that lets the clear override a fresh overflow. Other tests hold `tick_i` low across a transition and stop the run mid-count. A design that gated detection with the tick would miss that capture, and one that froze the counter instead of zeroing it would report a stale count after restart.

// File: rtl/pwcap_pkg.sv
package pwcap_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  function automatic logic edge_hit(edge_mode_e mode, logic rise, logic fall);
    case (mode)
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      EDGE_ANY:  edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pwcap_edge_det.sv
module pwcap_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_i,
  input  logic [1:0] edge_sel_i,
  output logic       hit_o
);
  import pwcap_pkg::*;

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sync_q;
  logic          prev_q;
  logic          rise;
  logic          fall;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[LAST-1:0], pin_i};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pin_i;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[LAST];
  end

  assign rise  = sync_q[LAST] & ~prev_q;
  assign fall  = ~sync_q[LAST] & prev_q;
  assign hit_o = edge_hit(edge_mode_e'(edge_sel_i), rise, fall);

endmodule

// File: rtl/pwcap_counter.sv
module pwcap_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             cap_pulse_o,
  output logic             ovf_pulse_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = run_i & tick_i & (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      cap_val_o   <= '0;
      cap_pulse_o <= 1'b0;
      ovf_pulse_o <= 1'b0;
    end else begin
      cap_pulse_o <= 1'b0;
      ovf_pulse_o <= wrap_o;
      if (!run_i) begin
        cnt_q <= '0;
      end else if (hit_i) begin
        cap_val_o   <= cnt_q;
        cnt_q       <= '0;
        cap_pulse_o <= 1'b1;
      end else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwcap_ovf_flag.sv
module pwcap_ovf_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  always_ff @(posedge clk) begin
    if (rst) flag_o <= 1'b0;
    else     flag_o <= set_i | (flag_o & ~clr_i);
  end

endmodule

// File: rtl/pwcap_timer.sv
module pwcap_timer #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             pin_i,
  input  logic             tick_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             cap_pulse_o,
  output logic             ovf_pulse_o,
  output logic             ovf_flag_o
);

  logic hit;
  logic wrap;

  pwcap_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst        (rst),
    .pin_i      (pin_i),
    .edge_sel_i (edge_sel_i),
    .hit_o      (hit)
  );

  pwcap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .run_i       (run_i),
    .tick_i      (tick_i),
    .hit_i       (hit),
    .cap_val_o   (cap_val_o),
    .cap_pulse_o (cap_pulse_o),
    .ovf_pulse_o (ovf_pulse_o),
    .wrap_o      (wrap)
  );

  pwcap_ovf_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .set_i  (wrap),
    .clr_i  (flag_clr_i),
    .flag_o (ovf_flag_o)
  );

endmodule

// File: rtl/pwcap_chk.sv
module pwcap_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run_i,
  input logic             flag_clr_i,
  input logic [CNT_W-1:0] cap_val_o,
  input logic             cap_pulse_o,
  input logic             ovf_pulse_o,
  input logic             ovf_flag_o
);

  // R2
  stopped_no_capture_chk: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (!cap_pulse_o && $stable(cap_val_o)));

  // R2
  stopped_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !ovf_pulse_o);

  // R3
  value_moves_on_capture_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_pulse_o |-> $stable(cap_val_o));

  // R6
  ovf_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse_o |=> !ovf_pulse_o);

  // R7
  ovf_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse_o |-> ovf_flag_o);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag_o && !flag_clr_i) |=> ovf_flag_o);

  // R7
  flag_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag_o) |-> ovf_pulse_o);

endmodule

bind pwcap_timer pwcap_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .run_i       (run_i),
  .flag_clr_i  (flag_clr_i),
  .cap_val_o   (cap_val_o),
  .cap_pulse_o (cap_pulse_o),
  .ovf_pulse_o (ovf_pulse_o),
  .ovf_flag_o  (ovf_flag_o)
);

// File: tb/tb_pwcap_timer.sv
`timescale 1ns/1ps
module tb_pwcap_timer;

  logic        clk = 1'b0;
  logic        rst;
  logic        run_i;
  logic [1:0]  edge_sel_i;
  logic        pin_i;
  logic        tick_i;
  logic        flag_clr_i;
  logic [15:0] cap_val_o;
  logic        cap_pulse_o;
  logic        ovf_pulse_o;
  logic        ovf_flag_o;

  int total = 0;
  int bad   = 0;
  int since = 0;

  always #5 clk = ~clk;

  pwcap_timer dut (
    .clk(clk), .rst(rst), .run_i(run_i), .edge_sel_i(edge_sel_i),
    .pin_i(pin_i), .tick_i(tick_i), .flag_clr_i(flag_clr_i),
    .cap_val_o(cap_val_o), .cap_pulse_o(cap_pulse_o),
    .ovf_pulse_o(ovf_pulse_o), .ovf_flag_o(ovf_flag_o)
  );

  // fields: [11] capture expected, [10:9] edge select, [8] pin level, [7:0] hold (>=1)
  localparam int NVEC = 13;
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b1, 2'd1, 1'b1, 8'd5},
    {1'b0, 2'd1, 1'b0, 8'd7},
    {1'b1, 2'd1, 1'b1, 8'd2},
    {1'b1, 2'd2, 1'b0, 8'd9},
    {1'b0, 2'd2, 1'b1, 8'd4},
    {1'b1, 2'd3, 1'b0, 8'd1},
    {1'b1, 2'd3, 1'b1, 8'd12},
    {1'b0, 2'd0, 1'b0, 8'd3},
    {1'b0, 2'd0, 1'b1, 8'd6},
    {1'b1, 2'd3, 1'b0, 8'd20},
    {1'b0, 2'd2, 1'b1, 8'd2},
    {1'b0, 2'd1, 1'b0, 8'd2},
    {1'b1, 2'd1, 1'b1, 8'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic toggle_wait;
    pin_i = ~pin_i;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] last_val;
    rst = 1'b1; run_i = 1'b0; edge_sel_i = 2'b00; pin_i = 1'b0;
    tick_i = 1'b1; flag_clr_i = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cap_val", cap_val_o, 0);
    chk("R1 pulses", {cap_pulse_o, ovf_pulse_o}, 0);
    chk("R1 flag", ovf_flag_o, 0);

    // R3 R4 table walk, ticks every cycle
    last_val = 16'h0;
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      if (i == 0) run_i = 1'b1;
      edge_sel_i = VEC[i][10:9];
      pin_i      = VEC[i][8];
      repeat (3) @(posedge clk);
      @(negedge clk);
      since += 3;
      chk($sformatf("R4 vector %0d pulse", i), cap_pulse_o, VEC[i][11]);
      if (VEC[i][11]) begin
        chk($sformatf("R3 vector %0d value", i), cap_val_o, since - 1);
        last_val = 16'(since - 1);
        since = 0;
      end else begin
        chk($sformatf("R4 vector %0d held", i), cap_val_o, last_val);
      end
      repeat (VEC[i][7:0]) @(posedge clk);
      since += VEC[i][7:0];
    end

    // R5: capture with ticks off
    @(negedge clk);
    tick_i = 1'b0; edge_sel_i = 2'b11;
    toggle_wait();
    chk("R5 capture without tick", cap_pulse_o, 1);
    repeat (20) @(posedge clk);
    @(negedge clk);
    toggle_wait();
    chk("R5 no ticks counted", cap_val_o, 0);
    tick_i = 1'b1;
    repeat (7) @(posedge clk);
    @(negedge clk);
    tick_i = 1'b0;
    toggle_wait();
    chk("R5 seven ticks", cap_val_o, 7);

    // R2: stop mid-count, edge ignored, restart from zero
    tick_i = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    run_i = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    toggle_wait();
    chk("R2 stopped pulse", cap_pulse_o, 0);
    chk("R2 stopped value", cap_val_o, 7);
    repeat (4) @(posedge clk);
    @(negedge clk);
    run_i = 1'b1;
    toggle_wait();
    chk("R2 restart value", cap_val_o, 2);

    // R6 R7: plain rollover, capture is at posedge P
    repeat (65535) @(posedge clk);
    @(negedge clk);
    chk("R6 before wrap", {ovf_pulse_o, ovf_flag_o}, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R6 wrap pulse", ovf_pulse_o, 1);
    chk("R7 flag set", ovf_flag_o, 1);
    @(negedge clk);
    chk("R6 pulse one cycle", ovf_pulse_o, 0);
    toggle_wait();
    chk("R6 counting after wrap", cap_val_o, 3);
    chk("R7 flag sticky", ovf_flag_o, 1);
    flag_clr_i = 1'b1;
    @(negedge clk);
    flag_clr_i = 1'b0;
    chk("R7 flag cleared", ovf_flag_o, 0);

    // R8 R9: capture and rollover on the same clock, clear strobe too
    repeat (65532) @(posedge clk);
    @(negedge clk);
    pin_i = ~pin_i;
    repeat (2) @(posedge clk);
    @(negedge clk);
    flag_clr_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    flag_clr_i = 1'b0;
    chk("R8 captured max", cap_val_o, 16'hFFFF);
    chk("R8 both pulses", {cap_pulse_o, ovf_pulse_o}, 2'b11);
    chk("R9 flag wins over clear", ovf_flag_o, 1);
    toggle_wait();
    chk("R8 counter cleared", cap_val_o, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule